// File: doc/BRIEF.md
# Asymmetric Uop Steering Stage

This stage sits between an aligned instruction queue and the rename stage of an out-of-order core. Each cycle it is offered up to three instructions, oldest in slot 0. Each instruction carries a precomputed uop count of one to four, or a flag saying that it is microcoded, together with a start index into a small internal microcode table. Only slot 0 has the wide port: it can produce up to four uops, or start the microcode sequencer. Slots 1 and 2 each produce one uop at most.

A younger instruction that needs more than one uop, that is microcoded, or that finds no free output lane is not taken. The stage reports how many instructions it took, oldest first, and the front end shifts its queue by that amount. The first instruction left behind therefore arrives in slot 0 on the next cycle. A microcoded instruction is taken in the cycle it starts. Its uops then stream from the table, three per cycle, until an entry marked as the end of the sequence has been sent. No further instruction is taken until that happens.

Uops leave in program order on a four-lane group with per-lane valid bits. The group is handed over as a unit. When `out_ready` is low, the group stays on display, nothing is taken and nothing advances. Output valid never depends on `out_ready`. A synchronous flush ends any running sequence.

Top module: `uop_steer`

## Requirements
- R1: After reset, with no valid input, `out_valid` is 0, `in_take` is 0 and no sequence runs.
- R2: A non-microcoded instruction in slot 0 with `nm1` field n (uop count n+1) fills lanes 0..n. Lane j carries {1'b0, tag, j[1:0]}, where tag is 8 bits and the word is 11 bits.
- R3: A valid single-uop instruction in slot 1 is issued in the lane just after slot 0's uops, provided slot 0 issued directly. Slot 2 is issued in the next lane only if slot 1 issued. Its uop is {1'b0, tag, 2'b00}. Valid lanes are always contiguous from lane 0.
- R4: A slot 1 or slot 2 instruction with a uop count above one emits nothing. No younger slot issues, and `in_take` counts only the older slots.
- R5: A single-uop younger instruction that would need a lane beyond lane 3 is not issued and not taken.
- R6: A microcoded instruction in slot 0 is taken alone (`in_take`=1). In the same cycle it emits table entries from its start index, and slots 1 and 2 emit nothing.
- R7: A microcoded instruction in slot 1 or slot 2 is never issued there and is treated as a multi-uop instruction.
- R8: While a sequence runs, lanes 0..2 carry up to three consecutive table entries, ending with the end-marked entry inclusive. Lane 3 stays idle, `in_take` is 0, and the sequence finishes in the cycle that sends the end entry.
- R9: Table entry k (5-bit index) emits uop {1'b1, 5'b0, k}. It is end-marked exactly when k[2:0] = 7.
- R10: While `out_ready` is 0, `in_take` is 0 and the sequencer state does not change. The uop group is still shown.
- R11: When `flush` is high, `out_valid` and `in_take` are 0 in that cycle, and the sequencer is idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Abort running sequence, suppress output this cycle |
| in_valid | input | 3 | Per-slot instruction valid, contiguous from slot 0 |
| in_ucode | input | 3 | Per-slot microcoded flag |
| in_nm1 | input | 6 | Per-slot uop count minus one, 2 bits each |
| in_tag | input | 24 | Per-slot 8-bit instruction tag |
| in_ridx | input | 15 | Per-slot 5-bit microcode start index |
| in_take | output | 2 | Number of instructions taken this cycle, oldest first |
| out_valid | output | 4 | Per-lane uop valid |
| out_uop | output | 44 | Four 11-bit uops, lane 0 in the low bits |
| out_ready | input | 1 | Downstream accepts the whole uop group |

## Verification
On every cycle, the assertions check the following: lane contiguity, that a running sequence neither takes input nor uses lane 3, that `in_take` never exceeds the valid count, that back-pressure freezes the sequencer, and that flush idles it. Which slot reaches which lane, the exact uop payloads, where a sequence ends given its start index, and whether the re-steer decision is right can only be shown by the bench's sweep. The sweep covers every mix of uop counts and microcoded flags over the three slots. A reference model tracks the sequencer alongside the design, under interleaved back-pressure and flushes.

// File: rtl/udec_pkg.sv
package udec_pkg;
  localparam int SLOTS   = 3;
  localparam int LANES   = 4;
  localparam int TAG_W   = 8;
  localparam int ROM_AW  = 5;
  localparam int UOP_W   = TAG_W + 3;
  localparam int SEG_W   = 3;   // sequences end at every 2**SEG_W boundary
  localparam int SEQ_RATE = 3;
endpackage

// File: rtl/udec_rom.sv
module udec_rom #(
  parameter int AW    = udec_pkg::ROM_AW,
  parameter int DW    = udec_pkg::UOP_W,
  parameter int RATE  = udec_pkg::SEQ_RATE,
  parameter int SEG_W = udec_pkg::SEG_W
) (
  input  logic [AW-1:0]      base,
  output logic [RATE*DW-1:0] rd_uop,
  output logic [RATE-1:0]    rd_end
);
  localparam int PAD = DW - 1 - AW;

  // one read port per uop delivered per sequencer cycle
  for (genvar p = 0; p < RATE; p++) begin : g_port
    logic [AW-1:0] addr;
    assign addr = base + AW'(p);
    assign rd_uop[p*DW +: DW] = {1'b1, {PAD{1'b0}}, addr};
    assign rd_end[p] = &addr[SEG_W-1:0];
  end
endmodule

// File: rtl/udec_steer.sv
module udec_steer #(
  parameter int TAG_W = udec_pkg::TAG_W,
  parameter int LANES = udec_pkg::LANES
) (
  input  logic [2:0]               v,
  input  logic [2:0]               u,
  input  logic [5:0]               nm1,
  input  logic [3*TAG_W-1:0]       tag,
  output logic [LANES-1:0]         lane_v,
  output logic [LANES*(TAG_W+3)-1:0] lane_uop,
  output logic [1:0]               take
);
  localparam int DW = TAG_W + 3;

  logic [2:0] c0;
  logic       iss0, iss1, iss2;

  assign c0   = {1'b0, nm1[1:0]} + 3'd1;
  assign iss0 = v[0] && !u[0];
  // narrow slots only take single-uop work, and only if a lane is free
  assign iss1 = iss0 && v[1] && !u[1] && (nm1[3:2] == 2'd0) && (c0 <= 3'd3);
  assign iss2 = iss1 && v[2] && !u[2] && (nm1[5:4] == 2'd0) && (c0 <= 3'd2);
  assign take = 2'(iss0) + 2'(iss1) + 2'(iss2);

  always_comb begin
    lane_v   = '0;
    lane_uop = '0;
    for (int l = 0; l < LANES; l++) begin
      if (iss0 && 3'(l) < c0) begin
        lane_v[l] = 1'b1;
        lane_uop[l*DW +: DW] = {1'b0, tag[0 +: TAG_W], 2'(l)};
      end else if (iss1 && 3'(l) == c0) begin
        lane_v[l] = 1'b1;
        lane_uop[l*DW +: DW] = {1'b0, tag[TAG_W +: TAG_W], 2'b00};
      end else if (iss2 && 3'(l) == c0 + 3'd1) begin
        lane_v[l] = 1'b1;
        lane_uop[l*DW +: DW] = {1'b0, tag[2*TAG_W +: TAG_W], 2'b00};
      end
    end
  end
endmodule

// File: rtl/uop_steer.sv
module uop_steer
  import udec_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [2:0]             in_valid,
  input  logic [2:0]             in_ucode,
  input  logic [5:0]             in_nm1,
  input  logic [23:0]            in_tag,
  input  logic [14:0]            in_ridx,
  output logic [1:0]             in_take,
  output logic [3:0]             out_valid,
  output logic [43:0]            out_uop,
  input  logic                   out_ready
);
  logic              seq_act;
  logic [ROM_AW-1:0] seq_ptr;
  logic [ROM_AW-1:0] rom_base;
  logic              rom_mode;
  logic [SEQ_RATE*UOP_W-1:0] rom_uop;
  logic [SEQ_RATE-1:0]       rom_end;
  logic [SEQ_RATE-1:0]       alive;
  logic                      seq_done;
  logic [LANES-1:0]          st_v;
  logic [LANES*UOP_W-1:0]    st_uop;
  logic [1:0]                st_take;
  logic [LANES-1:0]          rom_v;
  logic [LANES*UOP_W-1:0]    rom_lane;

  assign rom_mode = seq_act || (in_valid[0] && in_ucode[0]);
  assign rom_base = seq_act ? seq_ptr : in_ridx[ROM_AW-1:0];

  udec_rom i_rom (
    .base   (rom_base),
    .rd_uop (rom_uop),
    .rd_end (rom_end)
  );

  udec_steer i_steer (
    .v        (in_valid),
    .u        (in_ucode),
    .nm1      (in_nm1),
    .tag      (in_tag),
    .lane_v   (st_v),
    .lane_uop (st_uop),
    .take     (st_take)
  );

  // a port is live while no earlier port in this group ended the sequence
  for (genvar p = 0; p < SEQ_RATE; p++) begin : g_alive
    if (p == 0) begin : g_first
      assign alive[p] = 1'b1;
    end else begin : g_next
      assign alive[p] = alive[p-1] && !rom_end[p-1];
    end
  end
  assign seq_done = |(alive & rom_end);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l < SEQ_RATE) begin : g_rom
      assign rom_v[l] = alive[l];
      assign rom_lane[l*UOP_W +: UOP_W] = rom_uop[l*UOP_W +: UOP_W];
    end else begin : g_idle
      assign rom_v[l] = 1'b0;
      assign rom_lane[l*UOP_W +: UOP_W] = '0;
    end
  end

  assign out_valid = flush ? '0 : (rom_mode ? rom_v : st_v);
  assign out_uop   = rom_mode ? rom_lane : st_uop;
  assign in_take   = (flush || !out_ready) ? 2'd0 :
                     (rom_mode ? (seq_act ? 2'd0 : 2'd1) : st_take);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_act <= 1'b0;
      seq_ptr <= '0;
    end else if (flush) begin
      seq_act <= 1'b0;
    end else if (out_ready && rom_mode) begin
      seq_act <= !seq_done;
      seq_ptr <= rom_base + ROM_AW'(SEQ_RATE);
    end
  end

  a_r3_lanes_contig: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_valid & (out_valid + 4'd1)) == 4'd0));
  a_r8_seq_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    seq_act |-> (in_take == 2'd0));
  a_r8_lane3_idle: assert property (@(posedge clk) disable iff (!rst_n)
    seq_act |-> !out_valid[3]);
  a_r4_take_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(in_take) <= $countones(in_valid));
  a_r10_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && !flush) |=> ($stable(seq_act) && $stable(seq_ptr)));
  a_r11_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !seq_act);
  a_r11_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (out_valid == 4'd0 && in_take == 2'd0));
endmodule

// File: tb/test_uop_steer.sv
`timescale 1ns/1ps
module test_uop_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [2:0]  in_valid = '0, in_ucode = '0;
  logic [5:0]  in_nm1 = '0;
  logic [23:0] in_tag = '0;
  logic [14:0] in_ridx = '0;
  logic [1:0]  in_take;
  logic [3:0]  out_valid;
  logic [43:0] out_uop;
  logic        out_ready = 1'b1;

  int vectors = 0, fails = 0;
  bit m_act = 1'b0;
  logic [4:0] m_ptr = '0;

  always #2.5 clk = ~clk;

  uop_steer i_uop_steer (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model: computes expected lanes and take, then advances its own state
  task automatic step_model(input int vec);
    logic [3:0]  ev = '0;
    logic [10:0] eu [4];
    int take = 0, n = 0;
    string req;
    bit romm, done = 0;
    logic [4:0] p;
    for (int i = 0; i < 4; i++) eu[i] = '0;
    romm = m_act || (in_valid[0] && in_ucode[0]);
    if (flush) req = "R11";
    else if (m_act) req = "R8";
    else if (romm) req = "R6";
    else req = "R2/R3/R4/R5/R7";
    if (!out_ready) req = {req, "+R10"};
    if (!flush && romm) begin
      p = m_act ? m_ptr : in_ridx[4:0];
      for (int j = 0; j < 3; j++) begin
        if (!done) begin
          logic [4:0] a = p + 5'(j);
          ev[j] = 1'b1;
          eu[j] = {1'b1, 5'b0, a};          // R9 content
          if (a[2:0] == 3'd7) done = 1;
        end
      end
      take = m_act ? 0 : 1;
    end else if (!flush && in_valid[0]) begin
      int c0 = int'(in_nm1[1:0]) + 1;
      for (int j = 0; j < c0; j++) begin
        ev[j] = 1'b1;
        eu[j] = {1'b0, in_tag[7:0], 2'(j)};
      end
      n = c0; take = 1;
      for (int s = 1; s < 3; s++) begin
        if (take == s && in_valid[s] && !in_ucode[s] && in_nm1[2*s +: 2] == 2'd0 && n < 4) begin
          ev[n] = 1'b1;
          eu[n] = {1'b0, in_tag[8*s +: 8], 2'b00};
          n++; take++;
        end
      end
    end
    if (!out_ready) take = 0;
    chk(out_valid == ev, {req, " valid"}, int'(out_valid), int'(ev));
    chk(int'(in_take) == take, {req, " take"}, int'(in_take), take);
    for (int l = 0; l < 4; l++)
      if (ev[l]) chk(out_uop[11*l +: 11] == eu[l], {req, " uop"}, int'(out_uop[11*l +: 11]), int'(eu[l]));
    if (flush) m_act = 1'b0;
    else if (out_ready && romm) begin
      m_act = !done;
      m_ptr = p + 5'd3;
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: idle after reset
    chk(out_valid == 4'd0, "R1 valid", int'(out_valid), 0);
    chk(in_take == 2'd0, "R1 take", int'(in_take), 0);
    for (int pass = 0; pass < 2; pass++) begin
      for (int nv = 0; nv < 4; nv++) begin
        for (int k = 0; k < 125; k++) begin
          int vec = pass * 500 + nv * 125 + k;
          @(negedge clk);
          for (int s = 0; s < 3; s++) begin
            int kind = (k / (s == 0 ? 1 : (s == 1 ? 5 : 25))) % 5;
            in_valid[s]      = (s < nv);
            in_ucode[s]      = (kind == 4);   // R6, R7
            in_nm1[2*s +: 2] = 2'(kind % 4);  // R2, R4, R5
            in_tag[8*s +: 8] = 8'(vec * 3 + s);
            in_ridx[5*s +: 5] = 5'(vec * 5 + s * 7);
          end
          out_ready = (pass == 0) ? ((vec % 7) != 3) : ((vec % 3) != 1); // R10
          flush = ((vec % 23) == 11);                                     // R11
          #1;
          step_model(vec);
        end
      end
    end
    @(negedge clk);
    flush = 1'b0; in_valid = '0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(out_valid == 4'd0, "R8 drained", int'(out_valid), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule